// File: doc/BRIEF.md
# Channel Byte Ring Buffers

This block holds one serial channel's receive ring and transmit ring in a small byte store that both the host and the device side can reach. Each ring is a window of the store bounded by a base address and an inclusive last address, and the pointers wrap from the last address back to the base. On the receive ring the device side writes incoming bytes and the host consumes them by moving the read pointer. On the transmit ring the host deposits bytes and moves the write pointer, and the device side streams them out and moves the read pointer.

The host reaches the store through a byte port with one cycle of read latency. It configures the rings through a small register port. Two level outputs tell the host when to act: one when enough received bytes are waiting, the other when the transmit backlog has fallen to a low mark. Received bytes arrive as a valid-qualified stream with no back-pressure. Transmitted bytes leave on a valid/ready stream.

Top module: `rb_chan_rings`

## Requirements
- R1: After reset the receive window is 0 to DEPTH/2-1 and the transmit window is DEPTH/2 to DEPTH-1, all four pointers sit at their window base, the receive trigger is 1, the low mark is LOW_DEF, tx_valid and in_req are 0, and out_req is 1.
- R2: A received byte is written at the receive write pointer, and that pointer then moves to the next slot. The slot after the last address is the base address.
- R3: The receive ring holds at most last-base bytes because one slot always stays free. A byte that arrives while the ring is full is not stored, leaves the write pointer unchanged, and sets status bit 0 (overrun). Writing the status register with bit 0 set clears that bit.
- R4: tx_valid is 1 exactly when the transmit write and read pointers differ, and tx_data is the byte at the transmit read pointer. Each cycle with tx_valid and tx_ready moves the read pointer one slot, wrapping after the last address.
- R5: in_req is 1 when the receive ring is not empty and its byte count is at least the trigger register.
- R6: out_req is 1 when the transmit byte count is at most the low-mark register.
- R7: A command write with bit 0 set makes the receive write pointer equal to the receive read pointer, and one with bit 1 set makes the transmit read pointer equal to the transmit write pointer. Each takes effect at the next clock edge.
- R8: Writing a ring's base register (address 0 receive, 2 transmit) sets that base and both of the ring's pointers to the written value. Writing its last register (address 1 receive, 3 transmit) sets the last address and returns both pointers to the base.
- R9: The device-owned pointers are read-only to the host: receive write pointer at address 4, transmit read pointer at address 7. Host-owned pointers are at 5 (receive read) and 6 (transmit write). Trigger is at 8, low mark at 9, command at 10, status at 11.

Register addresses are those given in R8 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data, combinational from reg_addr |
| ram_we | input | 1 | Host byte-store write strobe |
| ram_addr | input | AW | Host byte-store address |
| ram_wdata | input | 8 | Host byte-store write data |
| ram_rdata | output | 8 | Byte at ram_addr, one cycle later |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit byte taken this cycle |
| in_req | output | 1 | Receive service request |
| out_req | output | 1 | Transmit service request |

## Verification
The assertions assume the host keeps every pointer it writes inside its window, with base at or below last. They also assume the host issues at most one register write per cycle. With those assumptions the device-owned pointers stay in bounds, a full receive ring holds still, and a waiting transmit byte is not withdrawn. The stimulus sweeps many base/last pairs and only ever writes host-owned pointers that lie in the window it has just configured. It accepts transmit bytes one at a time, so neither assumption is broken.

// File: rtl/ringbuf_pkg.sv
package ringbuf_pkg;

  // host register addresses; the bench and the brief rely on these values
  typedef enum logic [3:0] {
    RG_IN_BASE  = 4'd0,
    RG_IN_LAST  = 4'd1,
    RG_OUT_BASE = 4'd2,
    RG_OUT_LAST = 4'd3,
    RG_IN_WR    = 4'd4,
    RG_IN_RD    = 4'd5,
    RG_OUT_WR   = 4'd6,
    RG_OUT_RD   = 4'd7,
    RG_IN_TRIG  = 4'd8,
    RG_OUT_LOW  = 4'd9,
    RG_CMD      = 4'd10,
    RG_STAT     = 4'd11
  } rb_reg_e;

  localparam int CMD_FLUSH_IN  = 0;
  localparam int CMD_FLUSH_OUT = 1;
  localparam int STAT_OVERRUN  = 0;

endpackage

// File: rtl/rb_ring_calc.sv
// Occupancy arithmetic for one ring with arbitrary inclusive bounds.
module rb_ring_calc #(
  parameter int AW         = 6,
  parameter bit DEV_WRITES = 1'b1
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] last,
  input  logic [AW-1:0] wr,
  input  logic [AW-1:0] rd,
  output logic          empty,
  output logic          full,
  output logic [AW-1:0] count,
  output logic [AW-1:0] dev_next
);

  logic [AW-1:0] wr_step;
  logic [AW-1:0] span;

  always_comb begin
    wr_step = (wr == last) ? base : wr + 1'b1;
    span    = last - base + 1'b1;
    empty   = (wr == rd);
    full    = (wr_step == rd);
    // modular arithmetic keeps this correct even when span wraps to zero
    count   = wr - rd + ((wr >= rd) ? '0 : span);
  end

  generate
    if (DEV_WRITES) begin : g_dev_wr
      assign dev_next = wr_step;
    end else begin : g_dev_rd
      logic [AW-1:0] rd_step;
      assign rd_step  = (rd == last) ? base : rd + 1'b1;
      assign dev_next = rd_step;
    end
  endgenerate

endmodule

// File: rtl/rb_byte_store.sv
// Shared byte store: host port (registered read), device write port,
// device combinational read port.
module rb_byte_store #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [7:0]    h_wdata,
  output logic [7:0]    h_rdata,
  input  logic          d_we,
  input  logic [AW-1:0] d_waddr,
  input  logic [7:0]    d_wdata,
  input  logic [AW-1:0] d_raddr,
  output logic [7:0]    d_rdata
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  // device write is issued second so it wins an address collision
  always_ff @(posedge clk) begin
    if (h_we) mem[h_addr] <= h_wdata;
    if (d_we) mem[d_waddr] <= d_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h_rdata <= '0;
    else        h_rdata <= mem[h_addr];
  end

  assign d_rdata = mem[d_raddr];

endmodule

// File: rtl/rb_svc_req.sv
// Service request thresholds.
module rb_svc_req #(
  parameter int AW = 6
) (
  input  logic          in_empty,
  input  logic [AW-1:0] in_count,
  input  logic [AW-1:0] in_trig,
  input  logic [AW-1:0] out_count,
  input  logic [AW-1:0] out_low,
  output logic          in_req,
  output logic          out_req
);

  always_comb begin
    in_req  = !in_empty && (in_count >= in_trig);
    out_req = (out_count <= out_low);
  end

endmodule

// File: rtl/rb_chan_rings.sv
module rb_chan_rings
  import ringbuf_pkg::*;
#(
  parameter int AW      = 6,
  parameter int LOW_DEF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          ram_we,
  input  logic [AW-1:0] ram_addr,
  input  logic [7:0]    ram_wdata,
  output logic [7:0]    ram_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  output logic          in_req,
  output logic          out_req
);

  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DEPTH / 2;
  localparam logic [AW-1:0] IN_BASE_RST  = '0;
  localparam logic [AW-1:0] IN_LAST_RST  = AW'(HALF - 1);
  localparam logic [AW-1:0] OUT_BASE_RST = AW'(HALF);
  localparam logic [AW-1:0] OUT_LAST_RST = AW'(DEPTH - 1);
  localparam logic [AW-1:0] TRIG_RST     = AW'(1);
  localparam logic [AW-1:0] LOW_RST      = AW'(LOW_DEF);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // state
  logic [AW-1:0] in_base_q, in_last_q, out_base_q, out_last_q;
  logic [AW-1:0] in_wr_q, in_rd_q, out_wr_q, out_rd_q;
  logic [AW-1:0] in_trig_q, out_low_q;
  logic          overrun_q;

  logic [AW-1:0] in_base_d, in_last_d, out_base_d, out_last_d;
  logic [AW-1:0] in_wr_d, in_rd_d, out_wr_d, out_rd_d;
  logic [AW-1:0] in_trig_d, out_low_d;
  logic          overrun_d;

  // ring status
  logic          in_empty, in_full, out_empty, out_full;
  logic [AW-1:0] in_count, out_count, in_dev_next, out_dev_next;

  rb_ring_calc #(.AW(AW), .DEV_WRITES(1'b1)) u_in_ring (
    .base(in_base_q), .last(in_last_q), .wr(in_wr_q), .rd(in_rd_q),
    .empty(in_empty), .full(in_full), .count(in_count), .dev_next(in_dev_next)
  );

  rb_ring_calc #(.AW(AW), .DEV_WRITES(1'b0)) u_out_ring (
    .base(out_base_q), .last(out_last_q), .wr(out_wr_q), .rd(out_rd_q),
    .empty(out_empty), .full(out_full), .count(out_count), .dev_next(out_dev_next)
  );

  // datapath into the store
  logic       store_we;
  logic [7:0] dev_rdata;

  rb_byte_store #(.AW(AW)) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .h_we(ram_we), .h_addr(ram_addr), .h_wdata(ram_wdata), .h_rdata(ram_rdata),
    .d_we(store_we), .d_waddr(in_wr_q), .d_wdata(rx_data),
    .d_raddr(out_rd_q), .d_rdata(dev_rdata)
  );

  rb_svc_req #(.AW(AW)) u_svc (
    .in_empty(in_empty), .in_count(in_count), .in_trig(in_trig_q),
    .out_count(out_count), .out_low(out_low_q),
    .in_req(in_req), .out_req(out_req)
  );

  assign tx_valid = !out_empty;
  assign tx_data  = dev_rdata;

  logic tx_fire;
  logic ovr_set, ovr_clr;
  logic out_full_unused;

  assign tx_fire         = tx_valid && tx_ready;
  assign out_full_unused = out_full;

  // next state: device moves first, host writes take precedence
  always_comb begin
    in_base_d  = in_base_q;
    in_last_d  = in_last_q;
    out_base_d = out_base_q;
    out_last_d = out_last_q;
    in_wr_d    = in_wr_q;
    in_rd_d    = in_rd_q;
    out_wr_d   = out_wr_q;
    out_rd_d   = out_rd_q;
    in_trig_d  = in_trig_q;
    out_low_d  = out_low_q;
    store_we   = 1'b0;
    ovr_set    = 1'b0;
    ovr_clr    = 1'b0;

    if (rx_valid) begin
      if (!in_full) begin
        store_we = 1'b1;
        in_wr_d  = in_dev_next;
      end else begin
        ovr_set = 1'b1;
      end
    end

    if (tx_fire) out_rd_d = out_dev_next;

    if (reg_we) begin
      case (reg_addr)
        RG_IN_BASE: begin
          in_base_d = reg_wdata;
          in_wr_d   = reg_wdata;
          in_rd_d   = reg_wdata;
        end
        RG_IN_LAST: begin
          in_last_d = reg_wdata;
          in_wr_d   = in_base_q;
          in_rd_d   = in_base_q;
        end
        RG_OUT_BASE: begin
          out_base_d = reg_wdata;
          out_wr_d   = reg_wdata;
          out_rd_d   = reg_wdata;
        end
        RG_OUT_LAST: begin
          out_last_d = reg_wdata;
          out_wr_d   = out_base_q;
          out_rd_d   = out_base_q;
        end
        RG_IN_RD:   in_rd_d   = reg_wdata;
        RG_OUT_WR:  out_wr_d  = reg_wdata;
        RG_IN_TRIG: in_trig_d = reg_wdata;
        RG_OUT_LOW: out_low_d = reg_wdata;
        RG_CMD: begin
          if (reg_wdata[CMD_FLUSH_IN])  in_wr_d  = in_rd_q;
          if (reg_wdata[CMD_FLUSH_OUT]) out_rd_d = out_wr_q;
        end
        RG_STAT: ovr_clr = reg_wdata[STAT_OVERRUN];
        default: ;
      endcase
    end

    overrun_d = (overrun_q && !ovr_clr) || ovr_set;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      in_base_q  <= IN_BASE_RST;
      in_last_q  <= IN_LAST_RST;
      out_base_q <= OUT_BASE_RST;
      out_last_q <= OUT_LAST_RST;
      in_wr_q    <= IN_BASE_RST;
      in_rd_q    <= IN_BASE_RST;
      out_wr_q   <= OUT_BASE_RST;
      out_rd_q   <= OUT_BASE_RST;
      in_trig_q  <= TRIG_RST;
      out_low_q  <= LOW_RST;
      overrun_q  <= 1'b0;
    end else begin
      in_base_q  <= in_base_d;
      in_last_q  <= in_last_d;
      out_base_q <= out_base_d;
      out_last_q <= out_last_d;
      in_wr_q    <= in_wr_d;
      in_rd_q    <= in_rd_d;
      out_wr_q   <= out_wr_d;
      out_rd_q   <= out_rd_d;
      in_trig_q  <= in_trig_d;
      out_low_q  <= out_low_d;
      overrun_q  <= overrun_d;
    end
  end

  // register read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RG_IN_BASE:  reg_rdata = in_base_q;
      RG_IN_LAST:  reg_rdata = in_last_q;
      RG_OUT_BASE: reg_rdata = out_base_q;
      RG_OUT_LAST: reg_rdata = out_last_q;
      RG_IN_WR:    reg_rdata = in_wr_q;
      RG_IN_RD:    reg_rdata = in_rd_q;
      RG_OUT_WR:   reg_rdata = out_wr_q;
      RG_OUT_RD:   reg_rdata = out_rd_q;
      RG_IN_TRIG:  reg_rdata = in_trig_q;
      RG_OUT_LOW:  reg_rdata = out_low_q;
      RG_STAT:     reg_rdata = {{(AW-1){1'b0}}, overrun_q};
      default:     reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rb_chan_rings_chk.sv
module rb_chan_rings_chk
  import ringbuf_pkg::*;
#(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [3:0]    reg_addr,
  input logic [AW-1:0] reg_wdata,
  input logic          rx_valid,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          in_full,
  input logic          overrun,
  input logic [AW-1:0] in_base,
  input logic [AW-1:0] in_last,
  input logic [AW-1:0] in_wr,
  input logic [AW-1:0] in_rd,
  input logic [AW-1:0] out_base,
  input logic [AW-1:0] out_last,
  input logic [AW-1:0] out_rd
);

  logic in_cfg, out_cfg, fl_in, fl_out;

  assign in_cfg  = reg_we && (reg_addr == RG_IN_BASE || reg_addr == RG_IN_LAST || reg_addr == RG_CMD);
  assign out_cfg = reg_we && (reg_addr == RG_OUT_BASE || reg_addr == RG_OUT_LAST ||
                              reg_addr == RG_CMD || reg_addr == RG_OUT_WR);
  assign fl_in   = reg_we && (reg_addr == RG_CMD) && reg_wdata[CMD_FLUSH_IN];
  assign fl_out  = reg_we && (reg_addr == RG_CMD) && reg_wdata[CMD_FLUSH_OUT];

  // R3: arrival into a full ring flags an overrun
  assert_drop_sets_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && in_full |=> overrun);

  // R3: a full ring keeps its write pointer
  assert_full_holds_wp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && in_full && !in_cfg |=> in_wr == $past(in_wr));

  // R2: device write pointer stays inside its window
  assert_in_wp_bounds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_base <= in_last) |-> (in_wr >= in_base && in_wr <= in_last));

  // R4: device read pointer stays inside its window
  assert_out_rp_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_base <= out_last) |-> (out_rd >= out_base && out_rd <= out_last));

  // R4: a waiting transmit byte is not withdrawn without a host action
  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !out_cfg |=> tx_valid);

  // R7: receive flush leaves the ring empty
  assert_flush_in_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fl_in |=> in_wr == in_rd);

  // R7: transmit flush removes pending output
  assert_flush_out_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fl_out |=> !tx_valid);

endmodule

bind rb_chan_rings rb_chan_rings_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .rx_valid(rx_valid), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .in_full(in_full), .overrun(overrun_q),
  .in_base(in_base_q), .in_last(in_last_q), .in_wr(in_wr_q), .in_rd(in_rd_q),
  .out_base(out_base_q), .out_last(out_last_q), .out_rd(out_rd_q)
);

// File: tb/test_rb_chan_rings.sv
`timescale 1ns/1ps
module test_rb_chan_rings;

  localparam int AW  = 4;
  localparam int LOW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic          ram_we = 1'b0;
  logic [AW-1:0] ram_addr = '0;
  logic [7:0]    ram_wdata = '0;
  logic [7:0]    ram_rdata;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_data = '0;
  logic          tx_valid;
  logic [7:0]    tx_data;
  logic          tx_ready = 1'b0;
  logic          in_req, out_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rb_chan_rings #(.AW(AW), .LOW_DEF(LOW)) i_rb_chan_rings (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .in_req(in_req), .out_req(out_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input int d);
    reg_we    = 1'b1;
    reg_addr  = 4'(a);
    reg_wdata = AW'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input int a, output int d);
    reg_addr = 4'(a);
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic ram_wr(input int a, input int d);
    ram_we    = 1'b1;
    ram_addr  = AW'(a);
    ram_wdata = 8'(d);
    @(negedge clk);
    ram_we = 1'b0;
  endtask

  task automatic ram_rd(input int a, output int d);
    ram_addr = AW'(a);
    @(negedge clk);
    d = int'(ram_rdata);
  endtask

  task automatic rx_push(input int d);
    rx_valid = 1'b1;
    rx_data  = 8'(d);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tx_take();
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  function automatic int idat(int s, int len, int n);
    return (s * 37 + len * 11 + n * 5 + 1) & 255;
  endfunction

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    reg_rd(0, v);  check("R1 in base", v, 0);
    reg_rd(1, v);  check("R1 in last", v, 7);
    reg_rd(2, v);  check("R1 out base", v, 8);
    reg_rd(3, v);  check("R1 out last", v, 15);
    reg_rd(4, v);  check("R1 in wr", v, 0);
    reg_rd(7, v);  check("R1 out rd", v, 8);
    reg_rd(8, v);  check("R1 trig", v, 1);
    reg_rd(9, v);  check("R1 low", v, LOW);
    check("R1 tx_valid", int'(tx_valid), 0);
    check("R1 in_req", int'(in_req), 0);
    check("R1 out_req", int'(out_req), 1);

    // R9: device-owned receive write pointer ignores host writes
    reg_wr(4, 5);
    reg_rd(4, v);  check("R9 in wr read-only", v, 0);

    // receive ring sweep
    for (int s = 0; s < 4; s++) begin
      for (int len = 1; len <= 4; len++) begin
        int e, trig;
        e    = s + len;
        trig = (len + 1) / 2;
        reg_wr(0, s);
        reg_wr(1, e);
        reg_rd(4, v); check("R8 in wr at base", v, s);
        reg_rd(5, v); check("R8 in rd at base", v, s);
        reg_wr(8, trig);
        ram_wr(e, 8'hA5);
        for (int n = 1; n <= len; n++) begin
          rx_push(idat(s, len, n));
          reg_rd(4, v); check("R2 in wr advance", v, s + n);
          check("R5 in_req level", int'(in_req), (n >= trig) ? 1 : 0);
        end
        rx_push(8'h5A);
        reg_rd(4, v);  check("R3 full holds wr", v, e);
        reg_rd(11, v); check("R3 overrun set", v, 1);
        ram_rd(e, v);  check("R3 dropped byte not stored", v, 8'hA5);
        reg_wr(11, 1);
        reg_rd(11, v); check("R3 overrun cleared", v, 0);
        for (int i = 0; i < len; i++) begin
          ram_rd(s + i, v); check("R2 stored byte", v, idat(s, len, i + 1));
          reg_wr(5, s + i + 1);
        end
        check("R5 in_req after drain", int'(in_req), 0);
        rx_push(8'hC3);
        reg_rd(4, v);  check("R2 in wr wraps", v, s);
        ram_rd(e, v);  check("R2 byte at last slot", v, 8'hC3);
        check("R5 in_req one byte", int'(in_req), (trig <= 1) ? 1 : 0);
        reg_wr(10, 1);
        reg_rd(4, v);  check("R7 flush in wr", v, e);
        check("R7 flush in req", int'(in_req), 0);
      end
    end

    // transmit ring sweep
    for (int s = 8; s < 11; s++) begin
      for (int len = 1; len <= 3; len++) begin
        int e;
        e = s + len;
        reg_wr(2, s);
        reg_wr(3, e);
        reg_wr(9, 1);
        reg_rd(7, v); check("R8 out rd at base", v, s);
        reg_rd(6, v); check("R8 out wr at base", v, s);
        check("R4 empty no valid", int'(tx_valid), 0);
        check("R6 empty out_req", int'(out_req), 1);
        for (int i = 0; i < len; i++) ram_wr(s + i, idat(s, len, i) ^ 8'hFF);
        reg_wr(6, e);
        check("R6 loaded out_req", int'(out_req), (len <= 1) ? 1 : 0);
        reg_wr(7, s + 1);
        reg_rd(7, v); check("R9 out rd read-only", v, s);
        for (int i = 0; i < len; i++) begin
          check("R4 valid", int'(tx_valid), 1);
          check("R4 data", int'(tx_data), idat(s, len, i) ^ 8'hFF);
          tx_take();
          reg_rd(7, v); check("R4 rd advance", v, s + i + 1);
          check("R6 draining out_req", int'(out_req), ((len - i - 1) <= 1) ? 1 : 0);
        end
        check("R4 drained", int'(tx_valid), 0);
        ram_wr(e, 8'h3C);
        reg_wr(6, s);
        check("R4 wrap valid", int'(tx_valid), 1);
        check("R4 wrap data", int'(tx_data), 8'h3C);
        tx_take();
        reg_rd(7, v); check("R4 rd wraps", v, s);
        check("R4 wrap drained", int'(tx_valid), 0);
        ram_wr(s, 8'h77);
        reg_wr(6, s + 1);
        check("R7 pre-flush valid", int'(tx_valid), 1);
        reg_wr(10, 2);
        check("R7 flush out valid", int'(tx_valid), 0);
        reg_rd(7, v); check("R7 flush out rd", v, s + 1);
      end
    end

    done = 1'b1;
    finish_run();
  end

endmodule